// File: doc/BRIEF.md
# Serial EEPROM Write-Protection Flag and Command Unit

This block is the write-protection control of a two-wire serial EEPROM. It holds two protection flags, a permanent one and a reversible one. Both are modelled as registers whose reset values stand in for the non-volatile state. The bus shifter in front of the block delivers each received device-address byte with a strobe. The block decodes the protection commands that use device-type code 0110 and answers each one with ACK or NACK. The answer encodes the state of the relevant flag.

A set or clear command is only armed by its address byte. It is carried out when the framing logic reports a STOP that followed both dummy bytes, provided the WP pin stayed low for the whole command. The flag update is then scheduled on the shared write-cycle timer. A start request goes out, and the flag changes when the timer reports completion.

In parallel, the block gives a combinational permit for normal array writes. The permit depends on the target address, the WP pin and both flags. The lower half of the array can be locked by either flag. The whole array can be locked by WP.

Top module: `wp_guard`

## Requirements
- R1: While `wp` is high, `wr_permit` is 0 for every value of `wr_addr`.
- R2: While `wp` is low, `wr_permit` is 1 for addresses in the upper half (`wr_addr` >= 0x80). For addresses 0x00–0x7F it is 1 only when both flags are 0.
- R3: A byte is a protection command only when `dev_byte[7:4]` = 4'b0110. Any other type code gives no response (`resp_valid` stays 0).
  - With `hv_a0` high, the reversible form must also match: bit 3 = 0, `pin_a2` low, bit 2 equal to `pin_a1`, and bit 1 = 1. Bits {2,0} then select the operation: 00 set reversible, 01 read set-status, 10 clear reversible, 11 read clear-status.
  - With `hv_a0` low, bits 3:1 must equal {`pin_a2`,`pin_a1`,`pin_a0`}. Bit 0 = 0 selects set permanent and bit 0 = 1 selects read permanent.
  - A protection-type byte that matches neither form is NACKed.
- R4: `resp_valid` is high for exactly the cycle after a protection-type `addr_valid`. In that cycle `resp_ack` = 1 means ACK and 0 means NACK.
- R5: The following commands are ACKed only when the reversible flag is 0: set reversible and read set-status. The following are ACKed only when the permanent flag is 0: clear reversible and read clear-status.
- R6: Set permanent and read permanent are ACKed only when the permanent flag is 0. Once the permanent flag is 1, every protection-type byte is NACKed.
- R7: An ACKed set or clear takes effect only when `cmd_stop` arrives with `bytes_ok` = 1 and `wp` has been low from the address byte through the STOP. `wcyc_req` then pulses for one cycle, in the cycle after the STOP. The flag changes on the edge where `wcyc_done` is sampled.
- R8: If `wp` was high at any cycle of an armed command, the command is still ACKed. However, `wcyc_req` does not pulse and the flag keeps its value.
- R9: Status reads never raise `wcyc_req`, whatever `wp` is.
- R10: While a flag write cycle is pending, every protection-type byte is NACKed. This includes a byte that arrives in the same cycle as `wcyc_done`.
- R11: After reset both flags are 0. No command returns the permanent flag to 0.
- R12: A new `addr_valid` while a command is armed cancels the armed command. A later STOP then starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_valid | input | 1 | One-cycle strobe: `dev_byte` holds a received device-address byte |
| dev_byte | input | 8 | Device-address byte including the R/W bit |
| hv_a0 | input | 1 | A0 pin is at the high-voltage level |
| pin_a2 | input | 1 | Logic level of address pin A2 |
| pin_a1 | input | 1 | Logic level of address pin A1 |
| pin_a0 | input | 1 | Logic level of address pin A0 |
| wp | input | 1 | Write-protect pin level, 1 = high |
| cmd_stop | input | 1 | One-cycle strobe: STOP seen for the current command |
| bytes_ok | input | 1 | With `cmd_stop`: both dummy bytes were received |
| wcyc_done | input | 1 | One-cycle strobe: shared write-cycle timer finished |
| wr_addr | input | ADDR_W | Target address of a normal write |
| resp_valid | output | 1 | Response strobe for a protection-type byte |
| resp_ack | output | 1 | 1 = ACK, 0 = NACK, valid with `resp_valid` |
| wcyc_req | output | 1 | One-cycle request to start the shared write cycle |
| wr_permit | output | 1 | Normal write to `wr_addr` is allowed |

## Verification
Two events can land on the same clock edge: the completion of a flag write cycle, and the arrival of a new protection address. The bench provokes this by raising `wcyc_done` and `addr_valid` together, with the byte being a read of the flag that is being changed. The expected result is a NACK for that byte, because the unit is still busy on that edge. One cycle later, `wr_permit` for a lower-half address must already show the new flag value. A follow-up status read must then ACK in line with the updated flag.

// File: rtl/wp_pkg.sv
package wp_pkg;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_SET_R   = 3'd1,
    OP_CLR_R   = 3'd2,
    OP_SET_P   = 3'd3,
    OP_RD_SET  = 3'd4,
    OP_RD_CLR  = 3'd5,
    OP_RD_PERM = 3'd6
  } prot_op_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ARMED = 2'd1,
    S_BUSY  = 2'd2
  } seq_state_e;

  function automatic logic op_modifies(prot_op_e op);
    return (op == OP_SET_R) || (op == OP_CLR_R) || (op == OP_SET_P);
  endfunction

endpackage

// File: rtl/wp_cmd_decode.sv
module wp_cmd_decode
  import wp_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE = 4'b0110
) (
  input  logic [7:0] dev_byte,
  input  logic       hv_a0,
  input  logic       pin_a2,
  input  logic       pin_a1,
  input  logic       pin_a0,
  input  logic       perm_flag,
  input  logic       rev_flag,
  output logic       is_prot,
  output prot_op_e   op,
  output logic       grant
);

  logic rw;
  logic rev_match;
  logic perm_match;

  always_comb begin
    is_prot    = (dev_byte[7:4] == DEV_TYPE);
    rw         = dev_byte[0];
    rev_match  = hv_a0 && !dev_byte[3] && !pin_a2 &&
                 (dev_byte[2] == pin_a1) && dev_byte[1];
    perm_match = !hv_a0 && (dev_byte[3:1] == {pin_a2, pin_a1, pin_a0});
    op         = OP_NONE;
    if (is_prot) begin
      if (rev_match) begin
        unique case ({dev_byte[2], rw})
          2'b00:   op = OP_SET_R;
          2'b01:   op = OP_RD_SET;
          2'b10:   op = OP_CLR_R;
          default: op = OP_RD_CLR;
        endcase
      end else if (perm_match) begin
        op = rw ? OP_RD_PERM : OP_SET_P;
      end
    end
  end

  // ACK policy: the answer mirrors the flag the command concerns
  always_comb begin
    unique case (op)
      OP_SET_R, OP_RD_SET:                      grant = !rev_flag;
      OP_CLR_R, OP_RD_CLR, OP_SET_P, OP_RD_PERM: grant = !perm_flag;
      default:                                  grant = 1'b0;
    endcase
    if (perm_flag) grant = 1'b0;
  end

endmodule

// File: rtl/wp_flag_store.sv
module wp_flag_store #(
  parameter logic PERM_RST = 1'b0,
  parameter logic REV_RST  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_set_r,
  input  logic upd_clr_r,
  input  logic upd_set_p,
  output logic perm_flag,
  output logic rev_flag
);

  logic perm_q, perm_d;
  logic rev_q, rev_d;

  always_comb begin
    perm_d = perm_q | upd_set_p;   // no path back to 0
    rev_d  = rev_q;
    if (upd_set_r)      rev_d = 1'b1;
    else if (upd_clr_r) rev_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perm_q <= PERM_RST;
      rev_q  <= REV_RST;
    end else begin
      perm_q <= perm_d;
      rev_q  <= rev_d;
    end
  end

  assign perm_flag = perm_q;
  assign rev_flag  = rev_q;

endmodule

// File: rtl/wp_seq.sv
module wp_seq
  import wp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     addr_valid,
  input  logic     is_prot,
  input  prot_op_e op,
  input  logic     grant,
  input  logic     wp,
  input  logic     cmd_stop,
  input  logic     bytes_ok,
  input  logic     wcyc_done,
  output logic     resp_valid,
  output logic     resp_ack,
  output logic     wcyc_req,
  output logic     upd_set_r,
  output logic     upd_clr_r,
  output logic     upd_set_p
);

  seq_state_e state_q, state_d;
  prot_op_e   op_q, op_d;
  logic       wps_q, wps_d;
  logic       rv_q, rv_d;
  logic       ra_q, ra_d;
  logic       req_q, req_d;
  logic       commit;

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    wps_d   = wps_q;
    rv_d    = 1'b0;
    ra_d    = 1'b0;
    req_d   = 1'b0;
    commit  = 1'b0;
    unique case (state_q)
      S_BUSY: begin
        if (addr_valid && is_prot) rv_d = 1'b1;
        if (wcyc_done) begin
          commit  = 1'b1;
          state_d = S_IDLE;
        end
      end
      default: begin
        if (addr_valid) begin
          state_d = S_IDLE;
          if (is_prot) begin
            rv_d = 1'b1;
            ra_d = grant;
            if (grant && op_modifies(op)) begin
              state_d = S_ARMED;
              op_d    = op;
              wps_d   = wp;
            end
          end
        end else if (state_q == S_ARMED) begin
          if (cmd_stop) begin
            state_d = S_IDLE;
            if (bytes_ok && !wps_q && !wp) begin
              state_d = S_BUSY;
              req_d   = 1'b1;
            end
          end else begin
            wps_d = wps_q | wp;
          end
        end
      end
    endcase
  end

  always_comb begin
    upd_set_r = commit && (op_q == OP_SET_R);
    upd_clr_r = commit && (op_q == OP_CLR_R);
    upd_set_p = commit && (op_q == OP_SET_P);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      op_q    <= OP_NONE;
      wps_q   <= 1'b0;
      rv_q    <= 1'b0;
      ra_q    <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      wps_q   <= wps_d;
      rv_q    <= rv_d;
      ra_q    <= ra_d;
      req_q   <= req_d;
    end
  end

  assign resp_valid = rv_q;
  assign resp_ack   = ra_q;
  assign wcyc_req   = req_q;

endmodule

// File: rtl/wp_permit.sv
module wp_permit #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wp,
  input  logic              perm_flag,
  input  logic              rev_flag,
  output logic              permit
);

  localparam logic [ADDR_W:0] PROT_LIMIT = (ADDR_W+1)'(1) << (ADDR_W-1);

  logic in_low;

  always_comb begin
    in_low = ({1'b0, wr_addr} < PROT_LIMIT);
    permit = !wp && !(in_low && (perm_flag || rev_flag));
  end

endmodule

// File: rtl/wp_guard.sv
module wp_guard #(
  parameter int         ADDR_W   = 8,
  parameter logic [3:0] DEV_TYPE = 4'b0110,
  parameter logic       PERM_RST = 1'b0,
  parameter logic       REV_RST  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_valid,
  input  logic [7:0]        dev_byte,
  input  logic              hv_a0,
  input  logic              pin_a2,
  input  logic              pin_a1,
  input  logic              pin_a0,
  input  logic              wp,
  input  logic              cmd_stop,
  input  logic              bytes_ok,
  input  logic              wcyc_done,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              resp_valid,
  output logic              resp_ack,
  output logic              wcyc_req,
  output logic              wr_permit
);

  import wp_pkg::*;

  logic     perm_flag, rev_flag;
  logic     is_prot, grant;
  prot_op_e op;
  logic     upd_set_r, upd_clr_r, upd_set_p;

  wp_cmd_decode #(.DEV_TYPE(DEV_TYPE)) u_dec (
    .dev_byte  (dev_byte),
    .hv_a0     (hv_a0),
    .pin_a2    (pin_a2),
    .pin_a1    (pin_a1),
    .pin_a0    (pin_a0),
    .perm_flag (perm_flag),
    .rev_flag  (rev_flag),
    .is_prot   (is_prot),
    .op        (op),
    .grant     (grant)
  );

  wp_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_valid (addr_valid),
    .is_prot    (is_prot),
    .op         (op),
    .grant      (grant),
    .wp         (wp),
    .cmd_stop   (cmd_stop),
    .bytes_ok   (bytes_ok),
    .wcyc_done  (wcyc_done),
    .resp_valid (resp_valid),
    .resp_ack   (resp_ack),
    .wcyc_req   (wcyc_req),
    .upd_set_r  (upd_set_r),
    .upd_clr_r  (upd_clr_r),
    .upd_set_p  (upd_set_p)
  );

  wp_flag_store #(.PERM_RST(PERM_RST), .REV_RST(REV_RST)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_set_r (upd_set_r),
    .upd_clr_r (upd_clr_r),
    .upd_set_p (upd_set_p),
    .perm_flag (perm_flag),
    .rev_flag  (rev_flag)
  );

  wp_permit #(.ADDR_W(ADDR_W)) u_permit (
    .wr_addr   (wr_addr),
    .wp        (wp),
    .perm_flag (perm_flag),
    .rev_flag  (rev_flag),
    .permit    (wr_permit)
  );

endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wp,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_permit,
  input logic              addr_valid,
  input logic              resp_valid,
  input logic              cmd_stop,
  input logic              bytes_ok,
  input logic              wcyc_req,
  input logic              wcyc_done,
  input logic              perm_flag
);

  localparam logic [ADDR_W:0] HALF = (ADDR_W+1)'(1) << (ADDR_W-1);

  a_r1_wp_locks_all: assert property (@(posedge clk) disable iff (!rst_n)
    wp |-> !wr_permit);

  a_r2_upper_open: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp && ({1'b0, wr_addr} >= HALF)) |-> wr_permit);

  a_r4_resp_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(addr_valid));

  a_r7_req_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    wcyc_req |-> ($past(cmd_stop) && $past(bytes_ok) && !$past(wp)));

  a_r7_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    wcyc_req |=> !wcyc_req);

  a_r6_perm_rise_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perm_flag) |-> $past(wcyc_done));

  a_r11_perm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    perm_flag |=> perm_flag);

endmodule

bind wp_guard wp_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wp         (wp),
  .wr_addr    (wr_addr),
  .wr_permit  (wr_permit),
  .addr_valid (addr_valid),
  .resp_valid (resp_valid),
  .cmd_stop   (cmd_stop),
  .bytes_ok   (bytes_ok),
  .wcyc_req   (wcyc_req),
  .wcyc_done  (wcyc_done),
  .perm_flag  (perm_flag)
);

// File: tb/tb_wp_guard.sv
module tb_wp_guard;

  logic       clk;
  logic       rst_n;
  logic       addr_valid;
  logic [7:0] dev_byte;
  logic       hv_a0, pin_a2, pin_a1, pin_a0;
  logic       wp, cmd_stop, bytes_ok, wcyc_done;
  logic [7:0] wr_addr;
  logic       resp_valid, resp_ack, wcyc_req, wr_permit;

  int checks = 0;
  int errors = 0;

  wp_guard dut (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .dev_byte(dev_byte),
    .hv_a0(hv_a0), .pin_a2(pin_a2), .pin_a1(pin_a1), .pin_a0(pin_a0),
    .wp(wp), .cmd_stop(cmd_stop), .bytes_ok(bytes_ok), .wcyc_done(wcyc_done),
    .wr_addr(wr_addr), .resp_valid(resp_valid), .resp_ack(resp_ack),
    .wcyc_req(wcyc_req), .wr_permit(wr_permit)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_addr(input logic [7:0] b, output logic v, output logic a);
    @(negedge clk);
    addr_valid = 1'b1; dev_byte = b;
    @(negedge clk);
    addr_valid = 1'b0;
    v = resp_valid; a = resp_ack;
  endtask

  task automatic send_stop(input logic ok, output logic req);
    @(negedge clk);
    cmd_stop = 1'b1; bytes_ok = ok;
    @(negedge clk);
    cmd_stop = 1'b0; bytes_ok = 1'b0;
    req = wcyc_req;
  endtask

  task automatic finish_wcyc();
    @(negedge clk); wcyc_done = 1'b1;
    @(negedge clk); wcyc_done = 1'b0;
  endtask

  task automatic permit_at(input logic [7:0] a, output logic p);
    wr_addr = a; #1; p = wr_permit;
  endtask

  task automatic rev_mode(input logic a1);
    hv_a0 = 1'b1; pin_a2 = 1'b0; pin_a1 = a1; pin_a0 = 1'b0;
  endtask

  task automatic perm_mode();
    hv_a0 = 1'b0; pin_a2 = 1'b0; pin_a1 = 1'b0; pin_a0 = 1'b0;
  endtask

  task automatic t_reset();
    logic p, v, a;
    permit_at(8'h00, p); chk("R11 reset low half open", p, 1);
    permit_at(8'h80, p); chk("R2 reset high half open", p, 1);
    rev_mode(0); send_addr(8'h63, v, a);
    chk("R4 resp on read-set", v, 1); chk("R11 reversible clear at reset", a, 1);
    perm_mode(); send_addr(8'h61, v, a);
    chk("R6 read permanent ack at reset", a, 1);
  endtask

  task automatic t_wp_lock();
    logic p;
    wp = 1'b1;
    permit_at(8'h00, p); chk("R1 wp locks low", p, 0);
    permit_at(8'hFF, p); chk("R1 wp locks high", p, 0);
    wp = 1'b0;
  endtask

  task automatic t_foreign();
    logic v, a;
    rev_mode(0); send_addr(8'hA0, v, a);
    chk("R3 normal type no response", v, 0);
    send_addr(8'h6A, v, a);
    chk("R3 mismatch responds", v, 1); chk("R3 mismatch NACK", a, 0);
    perm_mode(); send_addr(8'h62, v, a);
    chk("R3 permanent pin mismatch NACK", a, 0);
  endtask

  task automatic t_set_rev();
    logic v, a, r, p;
    rev_mode(0); send_addr(8'h62, v, a);
    chk("R5 set reversible ack", a, 1);
    send_stop(1, r); chk("R7 set starts write cycle", r, 1);
    @(negedge clk); chk("R7 request is one cycle", wcyc_req, 0);
    permit_at(8'h10, p); chk("R7 flag waits for done", p, 1);
    finish_wcyc();
    permit_at(8'h10, p); chk("R2 low half locked by reversible", p, 0);
    permit_at(8'h90, p); chk("R2 high half still open", p, 1);
  endtask

  task automatic t_rev_nacks();
    logic v, a;
    rev_mode(0);
    send_addr(8'h63, v, a); chk("R5 read-set NACK when set", a, 0);
    send_addr(8'h62, v, a); chk("R5 set again NACK", a, 0);
    rev_mode(1);
    send_addr(8'h67, v, a); chk("R5 read-clear ack", a, 1);
  endtask

  task automatic t_wp_mid();
    logic v, a, r, p;
    rev_mode(1); send_addr(8'h66, v, a);
    chk("R8 clear acked", a, 1);
    @(negedge clk); wp = 1'b1;
    @(negedge clk); wp = 1'b0;
    send_stop(1, r); chk("R8 wp glitch suppresses cycle", r, 0);
    permit_at(8'h10, p); chk("R8 flag unchanged", p, 0);
  endtask

  task automatic t_no_bytes();
    logic v, a, r;
    rev_mode(1); send_addr(8'h66, v, a);
    send_stop(0, r); chk("R7 missing dummy bytes no cycle", r, 0);
  endtask

  task automatic t_cancel();
    logic v, a, r;
    rev_mode(1); send_addr(8'h66, v, a);
    send_addr(8'h67, v, a); chk("R5 read-clear ack while armed", a, 1);
    send_stop(1, r); chk("R12 cancelled command no cycle", r, 0);
  endtask

  task automatic t_clear_busy();
    logic v, a, r, p;
    rev_mode(1); send_addr(8'h66, v, a);
    send_stop(1, r); chk("R7 clear starts cycle", r, 1);
    rev_mode(0); send_addr(8'h63, v, a);
    chk("R10 busy responds", v, 1); chk("R10 busy NACK", a, 0);
    @(negedge clk);
    addr_valid = 1'b1; dev_byte = 8'h63; wcyc_done = 1'b1;
    @(negedge clk);
    addr_valid = 1'b0; wcyc_done = 1'b0;
    chk("R10 same-cycle done NACK", resp_ack, 0);
    permit_at(8'h10, p); chk("R7 clear applied on done", p, 1);
    send_addr(8'h63, v, a); chk("R5 read-set ack after clear", a, 1);
  endtask

  task automatic t_read_no_cycle();
    logic v, a, r;
    rev_mode(0); send_addr(8'h63, v, a);
    send_stop(1, r); chk("R9 status read no cycle", r, 0);
    wp = 1'b1; perm_mode(); send_addr(8'h61, v, a);
    chk("R9 read ignores wp", a, 1);
    send_stop(1, r); chk("R9 read with wp no cycle", r, 0);
    wp = 1'b0;
  endtask

  task automatic t_set_perm();
    logic v, a, r, p;
    perm_mode(); send_addr(8'h60, v, a);
    chk("R6 set permanent ack", a, 1);
    send_stop(1, r); chk("R7 permanent cycle", r, 1);
    finish_wcyc();
    permit_at(8'h00, p); chk("R2 permanent locks low", p, 0);
    permit_at(8'h80, p); chk("R2 permanent leaves high", p, 1);
    send_addr(8'h61, v, a); chk("R6 read permanent NACK", a, 0);
    rev_mode(0); send_addr(8'h63, v, a); chk("R6 all protection NACK", a, 0);
    rev_mode(1); send_addr(8'h66, v, a); chk("R11 clear refused", a, 0);
    send_stop(1, r); chk("R11 no cycle after refused", r, 0);
    permit_at(8'h00, p); chk("R11 permanent stays", p, 0);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog R7 actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr_valid = 1'b0; dev_byte = 8'h00;
    hv_a0 = 1'b0; pin_a2 = 1'b0; pin_a1 = 1'b0; pin_a0 = 1'b0;
    wp = 1'b0; cmd_stop = 1'b0; bytes_ok = 1'b0; wcyc_done = 1'b0;
    wr_addr = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 no response after reset", resp_valid, 0);
    chk("R7 no request after reset", wcyc_req, 0);
    t_reset();
    t_wp_lock();
    t_foreign();
    t_set_rev();
    t_rev_nacks();
    t_wp_mid();
    t_no_bytes();
    t_cancel();
    t_clear_busy();
    t_read_no_cycle();
    t_set_perm();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule